// File: doc/BRIEF.md
# Bus Trigger and Trace Capture Unit

This block watches a processor bus and keeps a short history of it. Two programmable comparators, A and B, are checked against every valid bus cycle. A 4-bit mode field decides how their matches combine into one trigger event. The trigger can also be made to wait until an instruction is actually executed at the address that matched. An eight-entry trace buffer is tied to the trigger. In a begin trace, recording starts after the trigger and stops when the buffer is full. In an end trace, the buffer records continuously and overwrites its oldest entries until the trigger freezes it.

Software loads the control byte and the two comparator values while the unit is disarmed, and then sets the arm bit. It polls the status word for completion and then pops the buffer, oldest entry first. Bus reads and bus writes are treated the same way: every valid cycle counts as an access.

The controller has five states. `ST_IDLE` is disarmed. `ST_WAIT` is armed, with a begin trace waiting for its trigger. `ST_CAP` is a begin trace that is recording. `ST_RING` is an end trace that records circularly. `ST_DONE` means the capture is complete and the arm bit is clear. The transitions are as follows:
- An arm request leaves `ST_IDLE` or `ST_DONE`. It goes to `ST_WAIT` when the effective trace direction is begin, and to `ST_RING` otherwise.
- In `ST_WAIT`, the trigger (or, in the event-only modes, the first stored event) moves to `ST_CAP`.
- In `ST_CAP`, the push that fills the buffer moves to `ST_DONE`.
- In `ST_RING`, the trigger moves to `ST_DONE`.
- A disarm write in `ST_WAIT`, `ST_CAP` or `ST_RING` returns to `ST_IDLE` and keeps the stored entries.

Top module: `bus_trig_trace`

## Requirements
- R1: After reset, all four registers read back as zero: the control byte, both comparators and the status word. The buffer level is 0, and the trigger and done flags are low.
- R2: The register at select 0 holds the control byte. Bits [3:0] are the mode, bit 6 is the trigger type (1 = tag) and bit 7 is begin. Bits 5:4 always read 0. Select 1 is comparator A and select 2 is comparator B. Select 3 is the status word: bit 0 arm, bit 1 done, bit 2 triggered. Writing bit 0 of select 3 arms (1) or disarms (0) the unit.
- R3: While the unit is armed, writes to selects 0, 1 and 2 are ignored.
- R4: Mode 0 fires on a bus access to address A. Mode 1 fires on an access to address A or to address B.
- R5: Mode 2 fires on a B access only after an earlier A access in the same run. A disarm forgets that earlier A access.
- R6: Mode 5 fires on an access to address A whose data equals the low 8 bits of B. Mode 6 fires on an access to address A whose data differs from them.
- R7: Mode 7 fires when A ≤ address ≤ B. Mode 8 fires when the address is below A or above B.
- R8: Modes 9 to 15 never fire.
- R9: With the trigger type set to tag, a qualifying access only records its address as pending. The trigger fires when the executed-opcode strobe reports that same address.
- R10: In a begin trace, the address of each valid bus cycle after the trigger is stored. After the eighth entry the run completes and arm clears.
- R11: In an end trace, the address of every valid bus cycle is stored, including the cycle that triggers. The buffer keeps only the newest 8 entries, and the trigger completes the run.
- R12: Modes 3 and 4 always run as a begin trace, whatever the begin bit says. In these modes, each B access stores its data byte, zero-extended to 16 bits. Mode 4 stores only after an earlier A access. The first stored event sets the triggered flag.
- R13: Entries are read back oldest first, one per pop. Pops have no effect while the unit is armed, and arming empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_sel |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 16 | Bus cycle address |
| bus_data | input | 8 | Bus cycle data |
| exec_valid | input | 1 | An opcode was executed |
| exec_addr | input | 16 | Address of the executed opcode |
| trig_flag | output | 1 | Trigger (or first event) seen in this run |
| cap_done | output | 1 | Capture complete |
| fifo_pop | input | 1 | Remove the oldest trace entry |
| fifo_dout | output | 16 | Oldest trace entry |
| fifo_level | output | 4 | Number of stored entries |

## Verification
The sequential mode is tested by giving a B access before an A access, and by disarming between an A access and a B access. A design that fired on B alone, or that kept the A access across the disarm, would complete where it must not. The end trace is overfilled to check that only the newest eight addresses survive and that they come back oldest first; a buffer that stopped when full, or that dropped the triggering cycle, returns the wrong sequence. Each range bound is probed exactly at A and at B, and one access just outside each bound is also tried, which exposes off-by-one comparisons. Tag mode is tested with an executed address that does not match, to catch a design that fires on the bus access alone. The event-only modes are run with the begin bit clear, to catch a design that honours that bit there.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CAP,
        ST_RING,
        ST_DONE
    } bt_state_e;

    localparam logic [3:0] MD_A      = 4'd0;
    localparam logic [3:0] MD_AORB   = 4'd1;
    localparam logic [3:0] MD_ATHENB = 4'd2;
    localparam logic [3:0] MD_EVB    = 4'd3;
    localparam logic [3:0] MD_AEVB   = 4'd4;
    localparam logic [3:0] MD_ADATB  = 4'd5;
    localparam logic [3:0] MD_ANDATB = 4'd6;
    localparam logic [3:0] MD_INRNG  = 4'd7;
    localparam logic [3:0] MD_OUTRNG = 4'd8;

    typedef struct packed {
        logic       begin_tr;
        logic       tag;
        logic [3:0] mode;
    } bt_ctrl_t;

endpackage

// File: rtl/bt_cmp.sv
module bt_cmp
    import bt_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_clr,
    input  logic          watch,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] cmp_a,
    input  logic [AW-1:0] cmp_b,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          cand,
    output logic          ev_store,
    output logic          seq_o
);

    logic hit_a, hit_b, dat_b, in_rng;
    logic seq_q;
    logic seq_mode;

    assign hit_a    = (bus_addr == cmp_a);
    assign hit_b    = (bus_addr == cmp_b);
    assign dat_b    = (bus_data == cmp_b[DW-1:0]);
    assign in_rng   = (bus_addr >= cmp_a) && (bus_addr <= cmp_b);
    assign seq_mode = (mode == MD_ATHENB) || (mode == MD_AEVB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= 1'b0;
        end else if (seq_clr) begin
            seq_q <= 1'b0;
        end else if (watch && bus_valid && hit_a && seq_mode) begin
            seq_q <= 1'b1;
        end
    end

    always_comb begin
        cand = 1'b0;
        unique case (mode)
            MD_A:      cand = hit_a;
            MD_AORB:   cand = hit_a || hit_b;
            MD_ATHENB: cand = seq_q && hit_b;
            MD_ADATB:  cand = hit_a && dat_b;
            MD_ANDATB: cand = hit_a && !dat_b;
            MD_INRNG:  cand = in_rng;
            MD_OUTRNG: cand = !in_rng;
            default:   cand = 1'b0;
        endcase
        cand = cand && bus_valid;
    end

    assign ev_store = bus_valid && hit_b &&
                      ((mode == MD_EVB) || ((mode == MD_AEVB) && seq_q));
    assign seq_o    = seq_q;

    // After a clear, the sequence flag must be low on the following cycle
    AST_SEQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> !seq_q); // R5

endmodule

// File: rtl/bt_tag.sv
module bt_tag #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          cand,
    input  logic [AW-1:0] bus_addr,
    input  logic          exec_valid,
    input  logic [AW-1:0] exec_addr,
    output logic          fire
);

    logic          pend_q;
    logic [AW-1:0] pend_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (clr) begin
            pend_q      <= 1'b0;
        end else if (en && cand) begin
            pend_q      <= 1'b1;
            pend_addr_q <= bus_addr;
        end
    end

    assign fire = en && pend_q && exec_valid && (exec_addr == pend_addr_q);

    // Without any executed opcode there can be no tagged trigger
    AST_TAG_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |-> !fire); // R9

endmodule

// File: rtl/bt_fifo.sv
module bt_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       overwrite,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int LW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [LW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    function automatic logic [LW-1:0] nxt(input logic [LW-1:0] p);
        return (p == LW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && (!full || overwrite);
    assign do_pop  = pop && (cnt_q != '0) && !push;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= nxt(wr_q);
            end
            if (do_push && full) begin
                rd_q <= nxt(rd_q);
            end else if (do_pop) begin
                rd_q <= nxt(rd_q);
            end
            if (do_push && !full) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (do_pop) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign dout  = mem[rd_q];
    assign level = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R13
    AST_RING_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && overwrite && !clr) |=> (cnt_q == CW'(DEPTH))); // R11

endmodule

// File: rtl/bus_trig_trace.sv
module bus_trig_trace
    import bt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          exec_valid,
    input  logic [AW-1:0] exec_addr,
    output logic          trig_flag,
    output logic          cap_done,
    input  logic          fifo_pop,
    output logic [AW-1:0] fifo_dout,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level
);

    localparam int CW = $clog2(DEPTH + 1);

    bt_state_e     state_q, state_d;
    bt_ctrl_t      ctrl_q;
    logic [AW-1:0] cmp_a_q, cmp_b_q;
    logic          trig_q;

    logic armed, arm_wr, arm_req, disarm_req, evt_mode, begin_eff, tag_en;
    logic watch, cand, ev_store, seq_flag, tag_fire, fire;
    logic fifo_push, trig_set, seq_clr, pop_ok, last_slot;
    logic [AW-1:0] push_data;

    assign armed      = (state_q == ST_WAIT) || (state_q == ST_CAP) || (state_q == ST_RING);
    assign arm_wr     = cfg_we && (cfg_sel == 2'd3);
    assign arm_req    = arm_wr && cfg_wdata[0] && !armed;
    assign disarm_req = arm_wr && !cfg_wdata[0] && armed;
    assign evt_mode   = (ctrl_q.mode == MD_EVB) || (ctrl_q.mode == MD_AEVB);
    assign begin_eff  = ctrl_q.begin_tr || evt_mode;
    assign tag_en     = ctrl_q.tag && !evt_mode;
    assign watch      = (state_q == ST_WAIT) || (state_q == ST_RING);
    assign last_slot  = (fifo_level == CW'(DEPTH - 1));

    // Register file: configuration is locked while armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (cfg_we && !armed) begin
            unique case (cfg_sel)
                2'd0:    ctrl_q  <= '{begin_tr: cfg_wdata[7], tag: cfg_wdata[6],
                                      mode: cfg_wdata[3:0]};
                2'd1:    cmp_a_q <= cfg_wdata[AW-1:0];
                2'd2:    cmp_b_q <= cfg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (cfg_sel)
            2'd0:    cfg_rdata = {8'h00, ctrl_q.begin_tr, ctrl_q.tag, 2'b00, ctrl_q.mode};
            2'd1:    cfg_rdata = cmp_a_q;
            2'd2:    cfg_rdata = cmp_b_q;
            default: cfg_rdata = {13'd0, trig_q, cap_done, armed};
        endcase
    end

    bt_cmp #(.AW(AW), .DW(DW)) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_clr   (seq_clr),
        .watch     (watch),
        .mode      (ctrl_q.mode),
        .cmp_a     (cmp_a_q),
        .cmp_b     (cmp_b_q),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .cand      (cand),
        .ev_store  (ev_store),
        .seq_o     (seq_flag)
    );

    bt_tag #(.AW(AW)) tag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (arm_req),
        .en         (tag_en && watch),
        .cand       (cand),
        .bus_addr   (bus_addr),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr),
        .fire       (tag_fire)
    );

    assign fire = tag_en ? tag_fire : cand;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (arm_req) state_d = begin_eff ? ST_WAIT : ST_RING;
            end
            ST_WAIT: begin
                if (disarm_req) begin
                    state_d = ST_IDLE;
                end else if (evt_mode) begin
                    if (ev_store) state_d = (DEPTH == 1) ? ST_DONE : ST_CAP;
                end else if (fire) begin
                    state_d = ST_CAP;
                end
            end
            ST_CAP: begin
                if (disarm_req) state_d = ST_IDLE;
                else if (fifo_push && last_slot) state_d = ST_DONE;
            end
            ST_RING: begin
                if (disarm_req) state_d = ST_IDLE;
                else if (fire) state_d = ST_DONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-state outputs
    always_comb begin
        fifo_push = 1'b0;
        trig_set  = 1'b0;
        seq_clr   = arm_req || disarm_req;
        unique case (state_q)
            ST_IDLE: seq_clr = 1'b1;
            ST_WAIT: begin
                if (!disarm_req) begin
                    fifo_push = evt_mode && ev_store;
                    trig_set  = evt_mode ? ev_store : fire;
                end
            end
            ST_CAP: begin
                if (!disarm_req) fifo_push = evt_mode ? ev_store : bus_valid;
            end
            ST_RING: begin
                if (!disarm_req) begin
                    fifo_push = bus_valid;
                    trig_set  = fire;
                end
            end
            ST_DONE: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        trig_q <= 1'b0;
        else if (arm_req)  trig_q <= 1'b0;
        else if (trig_set) trig_q <= 1'b1;
    end

    assign push_data = evt_mode ? {{(AW-DW){1'b0}}, bus_data} : bus_addr;
    assign pop_ok    = fifo_pop && !armed;

    bt_fifo #(.DEPTH(DEPTH), .W(AW)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (arm_req),
        .push      (fifo_push),
        .overwrite (state_q == ST_RING),
        .din       (push_data),
        .pop       (pop_ok),
        .dout      (fifo_dout),
        .level     (fifo_level)
    );

    assign trig_flag = trig_q;
    assign cap_done  = (state_q == ST_DONE);

    AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(ctrl_q)); // R3
    AST_BEGIN_FULL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAP && fifo_push && last_slot && !disarm_req)
        |=> (state_q == ST_DONE && fifo_level == CW'(DEPTH))); // R10
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ctrl_q.mode > MD_OUTRNG) |=> !trig_q); // R8
    AST_TAG_HOLDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RING && tag_en && !exec_valid && !disarm_req)
        |=> (state_q == ST_RING)); // R9
    AST_SEQ_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !seq_flag); // R5
    AST_EVT_IS_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && evt_mode) |=> (state_q == ST_WAIT)); // R12

endmodule

// File: tb/bus_trig_trace_tb.sv
module bus_trig_trace_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = 16'd0;
    logic [7:0]  bus_data = 8'd0;
    logic        exec_valid = 1'b0;
    logic [15:0] exec_addr = 16'd0;
    logic        trig_flag, cap_done;
    logic        fifo_pop = 1'b0;
    logic [15:0] fifo_dout;
    logic [3:0]  fifo_level;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q [$];

    always #2.5 clk = ~clk;

    bus_trig_trace dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .exec_valid(exec_valid),
        .exec_addr(exec_addr), .trig_flag(trig_flag), .cap_done(cap_done),
        .fifo_pop(fifo_pop), .fifo_dout(fifo_dout), .fifo_level(fifo_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] s, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] s, output logic [15:0] d);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    // Driver: one bus cycle; optionally records the expected trace entry
    task automatic bus(input logic [15:0] a, input logic [7:0] d,
                       input bit store, input bit ring, input logic [15:0] v);
        bus_valid = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
        if (store) begin
            exp_q.push_back(v);
            if (ring && exp_q.size() > 8) void'(exp_q.pop_front());
        end
    endtask

    task automatic exec(input logic [15:0] a);
        exec_valid = 1'b1; exec_addr = a;
        @(negedge clk);
        exec_valid = 1'b0;
    endtask

    task automatic arm(input logic [15:0] ctrl);
        cfg_wr(2'd0, ctrl);
        cfg_wr(2'd3, 16'd1);
        exp_q.delete();
    endtask

    // Monitor: pops the trace and compares against the scoreboard queue
    task automatic drain(input string req);
        chk({req, " level"}, int'(fifo_level), exp_q.size());
        for (int k = 0; k < 16 && fifo_level != 0; k++) begin
            logic [15:0] e;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'hDEAD;
            chk({req, " entry"}, int'(fifo_dout), int'(e));
            fifo_pop = 1'b1;
            @(negedge clk);
            fifo_pop = 1'b0;
        end
        chk({req, " leftover"}, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_rd(2'd0, r); chk("R1 ctrl", r, 0);
        cfg_rd(2'd1, r); chk("R1 cmpA", r, 0);
        cfg_rd(2'd3, r); chk("R1 status", r, 0);
        chk("R1 level", fifo_level, 0);
        chk("R1 trig", trig_flag, 0);
        chk("R1 done", cap_done, 0);

        // R2 layout, reserved bits
        cfg_wr(2'd0, 16'h00FF); cfg_rd(2'd0, r); chk("R2 reserved bits", r, 16'h00CF);
        cfg_wr(2'd1, 16'h1000); cfg_wr(2'd2, 16'h2000);
        cfg_rd(2'd2, r); chk("R2 cmpB", r, 16'h2000);

        // R4 mode 0 + R10 begin trace + R3 lock
        arm(16'h0080);
        cfg_rd(2'd3, r); chk("R2 armed status", r, 1);
        cfg_wr(2'd0, 16'h0035); cfg_rd(2'd0, r); chk("R3 ctrl locked", r, 16'h0080);
        cfg_wr(2'd1, 16'h7777); cfg_rd(2'd1, r); chk("R3 cmpA locked", r, 16'h1000);
        bus(16'h0F00, 0, 0, 0, 0);
        chk("R4 no fire on miss", trig_flag, 0);
        bus(16'h1000, 0, 0, 0, 0);
        chk("R4 fire on A", trig_flag, 1);
        for (int i = 0; i < 8; i++) bus(16'h3000 + 16'(i), 0, 1, 0, 16'h3000 + 16'(i));
        cfg_rd(2'd3, r); chk("R10 done, arm clear", r, 6);
        // R13 pop-ignored test happens later; drain here
        drain("R10");

        // R11 end trace, mode 1 fires on B
        arm(16'h0001);
        for (int i = 0; i < 10; i++) bus(16'h4000 + 16'(i), 0, 1, 1, 16'h4000 + 16'(i));
        chk("R11 not done yet", cap_done, 0);
        bus(16'h2000, 0, 1, 1, 16'h2000);
        chk("R4 fire on B", cap_done, 1);
        drain("R11");

        // R5 sequence A then B
        arm(16'h0002);
        bus(16'h2000, 0, 1, 1, 16'h2000);
        chk("R5 B alone", cap_done, 0);
        bus(16'h1000, 0, 1, 1, 16'h1000);
        bus(16'h5000, 0, 1, 1, 16'h5000);
        bus(16'h2000, 0, 1, 1, 16'h2000);
        chk("R5 A then B", cap_done, 1);
        drain("R5");

        // R5 disarm forgets A
        arm(16'h0002);
        bus(16'h1000, 0, 0, 0, 0);
        cfg_wr(2'd3, 16'd0);
        arm(16'h0002);
        bus(16'h2000, 0, 1, 1, 16'h2000);
        chk("R5 flag cleared", trig_flag, 0);
        cfg_wr(2'd3, 16'd0);
        drain("R5 rearm");

        // R12 event-only B, begin bit clear
        arm(16'h0003);
        for (int i = 0; i < 8; i++) begin
            bus(16'h1234, 8'h22, 0, 0, 0);
            bus(16'h2000, 8'h40 + 8'(i), 1, 0, 16'h0040 + 16'(i));
            if (i == 0) begin
                chk("R12 first event trig", trig_flag, 1);
                chk("R12 not done after one", cap_done, 0);
            end
        end
        chk("R12 done after eight", cap_done, 1);
        drain("R12 mode3");

        // R12 mode 4 needs A first
        arm(16'h0004);
        bus(16'h2000, 8'h55, 0, 0, 0);
        chk("R12 B before A stores nothing", fifo_level, 0);
        bus(16'h1000, 8'h00, 0, 0, 0);
        bus(16'h2000, 8'h66, 1, 0, 16'h0066);
        chk("R12 mode4 trig", trig_flag, 1);
        cfg_wr(2'd3, 16'd0);
        drain("R12 mode4");

        // R6 data qualified
        cfg_wr(2'd2, 16'h00AB);
        arm(16'h0005);
        bus(16'h1000, 8'h12, 1, 1, 16'h1000);
        chk("R6 mode5 wrong data", cap_done, 0);
        bus(16'h1000, 8'hAB, 1, 1, 16'h1000);
        chk("R6 mode5 match", cap_done, 1);
        drain("R6 mode5");
        arm(16'h0006);
        bus(16'h1000, 8'hAB, 1, 1, 16'h1000);
        bus(16'h1001, 8'h00, 1, 1, 16'h1001);
        chk("R6 mode6 no fire", cap_done, 0);
        bus(16'h1000, 8'h01, 1, 1, 16'h1000);
        chk("R6 mode6 fire", cap_done, 1);
        drain("R6 mode6");

        // R7 range modes
        cfg_wr(2'd2, 16'h10FF);
        arm(16'h0007);
        bus(16'h0FFF, 0, 1, 1, 16'h0FFF);
        bus(16'h1100, 0, 1, 1, 16'h1100);
        chk("R7 inside: outside ignored", cap_done, 0);
        bus(16'h10FF, 0, 1, 1, 16'h10FF);
        chk("R7 inside upper bound", cap_done, 1);
        drain("R7 inside");
        arm(16'h0008);
        bus(16'h1000, 0, 1, 1, 16'h1000);
        bus(16'h1080, 0, 1, 1, 16'h1080);
        bus(16'h10FF, 0, 1, 1, 16'h10FF);
        chk("R7 outside: bounds ignored", cap_done, 0);
        bus(16'h1100, 0, 1, 1, 16'h1100);
        chk("R7 outside fire", cap_done, 1);
        drain("R7 outside");

        // R8 reserved code
        arm(16'h0009);
        for (int i = 0; i < 12; i++) bus(16'h1000 + 16'(i * 64), 0, 1, 1, 16'h1000 + 16'(i * 64));
        chk("R8 no trigger", trig_flag, 0);
        chk("R8 no done", cap_done, 0);
        cfg_wr(2'd3, 16'd0);
        drain("R8");

        // R9 tag
        arm(16'h0040);
        bus(16'h1000, 0, 1, 1, 16'h1000);
        chk("R9 access alone", trig_flag, 0);
        exec(16'h1001);
        chk("R9 other exec", cap_done, 0);
        exec(16'h1000);
        chk("R9 exec at pending", cap_done, 1);
        drain("R9");

        // R13 pop ignored while armed, arming clears
        arm(16'h0000);
        bus(16'h7000, 0, 1, 1, 16'h7000);
        fifo_pop = 1'b1; @(negedge clk); fifo_pop = 1'b0;
        chk("R13 pop while armed", fifo_level, 1);
        cfg_wr(2'd3, 16'd0);
        cfg_wr(2'd3, 16'd1);
        chk("R13 arm clears", fifo_level, 0);
        cfg_wr(2'd3, 16'd0);
        exp_q.delete();
        drain("R13");

        finish_run();
    end

endmodule